// File: doc/BRIEF.md
# Tri-State Shift-Right Register with Parallel Load

This block is a small storage register of `WIDTH` stages (four by default). On every falling clock edge it does one of two things, picked by a single mode input: it copies a parallel word into all stages at once, or it moves every stage one place toward the last stage while a serial data bit enters the first stage. An active-low reset input clears every stage at once, without waiting for a clock edge, and wins over both modes.

The stage contents reach the outside in two ways. The main data outputs are tri-state: an active-low enable lets them drive the stored word or leaves them in high impedance. The register keeps loading, shifting and clearing while the outputs are off. A separate cascade output always drives the value of the last stage, so the serial input of a second register can be fed from it to build a longer chain. A shift toward the first stage needs no extra mode: the user wires each output back to the parallel input one place lower, holds the mode at load, and uses the top parallel input as the incoming bit.

Top module: `shr_tristate`

## Requirements
- R1: The stored word changes only on a falling clock edge; a rising edge leaves the outputs unchanged while reset is high.
- R2: With `sel_load` = 1, a falling edge copies `par_in[i]` into stage i for every i.
- R3: With `sel_load` = 0, a falling edge moves stage i into stage i+1 for every i below `WIDTH-1` and puts `ser_in` into stage 0.
- R4: While `rst_n` is 0 every stage is 0, from the moment it falls and through any clock edges, whatever the mode and data inputs.
- R5: With `oe_n` = 1 every bit of `dout` is high impedance, and loads and shifts still update the stages (visible on `cas_out` and after re-enabling).
- R6: `cas_out` always equals the last stage, stage `WIDTH-1`, whatever `oe_n` is.
- R7: After `rst_n` rises the register holds all zeros until the next falling clock edge.
- R8: `ser_in`, `par_in` and `sel_load` matter only at the falling edge; changes that are undone before the edge have no effect.
- R9: Two registers chained with `cas_out` of the first feeding `ser_in` of the second act as one shift register of twice the width, stage 0 of the first being the entry point.
- R10: With `sel_load` = 1, `par_in[i]` tied to `dout[i+1]` and `par_in[WIDTH-1]` used as the input bit, each falling edge moves stage i+1 into stage i and the input bit into the last stage.
- R11: With `oe_n` = 0, `dout[i]` shows stage i, and shows a new value in the same clock period in which the stage was updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register acts on its falling edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel_load | input | 1 | Mode: 1 = parallel load, 0 = shift toward the last stage |
| ser_in | input | 1 | Serial bit entering stage 0 in shift mode |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i in load mode |
| oe_n | input | 1 | Output enable for `dout`, active low |
| dout | output | WIDTH | Tri-state stage outputs; bit i is stage i |
| cas_out | output | 1 | Always-driven copy of the last stage for chaining |

## Verification
The edge properties take for granted that the mode and data inputs are settled at each falling edge and that any reset pulse stays low across at least one falling edge, so that a cleared stage is never seen half-way through its edge. The stimulus changes inputs only just after a rising edge, restores any deliberate disturbance well before the next falling edge, and drops and releases reset away from both edges. The output-enable check observes high impedance through pull-ups on the main outputs in the bench, so a released output reads as all ones there.

// File: rtl/shr_pkg.sv
package shr_pkg;

   typedef enum logic {
      MODE_SHIFT = 1'b0,
      MODE_LOAD  = 1'b1
   } mode_e;

   function automatic logic pick_next(input mode_e mode,
                                      input logic  shift_d,
                                      input logic  load_d);
      return (mode == MODE_LOAD) ? load_d : shift_d;
   endfunction

endpackage

// File: rtl/shr_stage_cell.sv
module shr_stage_cell
   import shr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  mode_e mode,
   input  logic  shift_d,
   input  logic  load_d,
   output logic  q
);

   logic d_next;

   always_comb begin
      d_next = pick_next(mode, shift_d, load_d);
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else begin
         q <= d_next;
      end
   end

endmodule

// File: rtl/shr_out_drv.sv
module shr_out_drv #(
   parameter int WIDTH = 4
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] dout
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign dout[i] = oe_n ? 1'bz : data[i];
   end

endmodule

// File: rtl/shr_tristate.sv
module shr_tristate #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_load,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   input  logic             oe_n,
   output logic [WIDTH-1:0] dout,
   output logic             cas_out
);

   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_bad
      $error("shr_tristate: WIDTH must be at least 2");
   end

   shr_pkg::mode_e   mode;
   logic [WIDTH-1:0] state_q;

   assign mode = shr_pkg::mode_e'(sel_load);

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic shift_src;
      if (i == 0) begin : g_head
         assign shift_src = ser_in;
      end else begin : g_body
         assign shift_src = state_q[i-1];
      end

      shr_stage_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (mode),
         .shift_d (shift_src),
         .load_d  (par_in[i]),
         .q       (state_q[i])
      );
   end

   shr_out_drv #(.WIDTH(WIDTH)) u_drv (
      .oe_n (oe_n),
      .data (state_q),
      .dout (dout)
   );

   assign cas_out = state_q[LAST];

endmodule

// File: rtl/shr_tristate_chk.sv
module shr_tristate_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_load,
   input logic             ser_in,
   input logic [WIDTH-1:0] par_in,
   input logic             oe_n,
   input logic [WIDTH-1:0] dout,
   input logic             cas_out,
   input logic [WIDTH-1:0] state
);

   logic armed;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else begin
         armed <= 1'b1;
      end
   end

   assert_load_R2: assert property (@(negedge clk) disable iff (!rst_n || !armed)
      $past(sel_load) |-> (state == $past(par_in)));

   assert_shift_R3: assert property (@(negedge clk) disable iff (!rst_n || !armed)
      !$past(sel_load) |-> (state == {$past(state[WIDTH-2:0]), $past(ser_in)}));

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_clear_R4: assert (state == '0);
      end
   end

   assert_cascade_R6: assert property (@(negedge clk) disable iff (!rst_n)
      !oe_n |-> (dout[WIDTH-1] == cas_out));

endmodule

bind shr_tristate shr_tristate_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_load (sel_load),
   .ser_in   (ser_in),
   .par_in   (par_in),
   .oe_n     (oe_n),
   .dout     (dout),
   .cas_out  (cas_out),
   .state    (state_q)
);

// File: tb/shr_tristate_bench.sv
module shr_tristate_bench;

   typedef struct {
      logic [3:0] dq;
      logic       cas;
      logic [7:0] ch;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       sel = 1'b1, ser = 1'b0, oen = 1'b0, lmode = 1'b0, lser = 1'b0;
   logic [3:0] par_drv = 4'h0;
   logic       csel = 1'b1, cser = 1'b0;
   logic [7:0] cpar = 8'h00;

   wire  [3:0] dq;
   wire        casq;
   wire  [3:0] par_main;
   wire  [3:0] lo_q, hi_q;
   wire        lo_cas, hi_cas;

   logic [3:0] mdl = 4'h0;
   logic [7:0] cmdl = 8'h00;
   item_t      sb[$];
   int         n_chk = 0;
   int         n_bad = 0;

   always #10 clk = ~clk;

   for (genvar i = 0; i < 4; i++) begin : g_pull
      pullup pu (dq[i]);
   end

   // left-shift feedback wiring (R10)
   assign par_main = lmode ? {lser, dq[3:1]} : par_drv;

   shr_tristate #(.WIDTH(4)) u_shr_tristate (
      .clk(clk), .rst_n(rst_n), .sel_load(sel), .ser_in(ser), .par_in(par_main),
      .oe_n(oen), .dout(dq), .cas_out(casq));

   shr_tristate #(.WIDTH(4)) u_chain_lo (
      .clk(clk), .rst_n(rst_n), .sel_load(csel), .ser_in(cser), .par_in(cpar[3:0]),
      .oe_n(1'b0), .dout(lo_q), .cas_out(lo_cas));

   shr_tristate #(.WIDTH(4)) u_chain_hi (
      .clk(clk), .rst_n(rst_n), .sel_load(csel), .ser_in(lo_cas), .par_in(cpar[7:4]),
      .oe_n(1'b0), .dout(hi_q), .cas_out(hi_cas));

   function automatic logic [3:0] seen(input logic [3:0] m, input logic oe);
      return oe ? 4'hF : m;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: pops one expected item per falling edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.req, {28'h0, dq}, {28'h0, it.dq});
            check("R6", {31'h0, casq}, {31'h0, it.cas});
            check("R9", {24'h0, hi_q, lo_q}, {24'h0, it.ch});
         end
      end
   end

   // driver: applies one cycle of stimulus and pushes the expected result
   task automatic drive(input logic s, input logic sd, input logic [3:0] p, input logic oe,
                        input logic lm, input logic ls, input logic cs, input logic csd,
                        input logic [7:0] cp, input logic gl, input string req);
      item_t it;
      @(posedge clk);
      #1;
      check("R1", {28'h0, dq}, {28'h0, seen(mdl, oen)});
      sel = s; ser = sd; par_drv = p; oen = oe; lmode = lm; lser = ls;
      csel = cs; cser = csd; cpar = cp;
      if (lm)       mdl = {ls, mdl[3:1]};
      else if (s)   mdl = p;
      else          mdl = {mdl[2:0], sd};
      if (cs)       cmdl = cp;
      else          cmdl = {cmdl[6:0], csd};
      it.dq = seen(mdl, oe); it.cas = mdl[3]; it.ch = cmdl; it.req = req;
      sb.push_back(it);
      if (gl) begin
         #3;
         sel = ~s; ser = ~sd; par_drv = ~p;
         #4;
         sel = s; ser = sd; par_drv = p;
      end
   endtask

   task automatic do_reset(input logic [3:0] pv);
      #7;
      rst_n = 1'b0;
      #2;
      check("R4", {28'h0, dq}, 32'h0);
      check("R4", {31'h0, casq}, 32'h0);
      sel = 1'b1; par_drv = 4'hF; lmode = 1'b0; oen = 1'b0; csel = 1'b1; cpar = 8'h00;
      @(negedge clk);
      #5;
      check("R4", {28'h0, dq}, 32'h0);
      par_drv = pv;
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      #4;
      check("R7", {28'h0, dq}, 32'h0);
      @(negedge clk);
      #5;
      check("R2", {28'h0, dq}, {28'h0, pv});
      mdl = pv;
      cmdl = 8'h00;
   endtask

   initial begin
      logic [5:0] spat;
      logic [3:0] opat;
      logic [3:0] lpat;
      spat = 6'b101100;
      opat = 4'b0110;
      lpat = 4'b1101;
      do_reset(4'h9);
      // parallel loads; chain loaded then starts shifting (R2, R9)
      drive(1, 0, 4'h5, 0, 0, 0, 1, 0, 8'hA5, 0, "R2");
      drive(1, 0, 4'hA, 0, 0, 0, 0, 1, 8'h00, 0, "R2");
      drive(1, 0, 4'hF, 0, 0, 0, 0, 1, 8'h00, 0, "R2");
      drive(1, 0, 4'h0, 0, 0, 0, 0, 0, 8'h00, 0, "R11");
      // right shifts (R3)
      for (int i = 0; i < 6; i++)
         drive(0, spat[i], 4'h0, 0, 0, 0, 0, spat[5-i], 8'h00, 0, "R3");
      // outputs off, register keeps moving (R5)
      for (int i = 0; i < 4; i++)
         drive(0, opat[i], 4'h0, 1, 0, 0, 0, opat[i], 8'h00, 0, "R5");
      drive(0, 1, 4'h0, 0, 0, 0, 0, 1, 8'h00, 0, "R11");
      // disturbances between edges (R8)
      drive(1, 0, 4'h6, 0, 0, 0, 0, 0, 8'h00, 1, "R8");
      drive(0, 1, 4'h0, 0, 0, 0, 0, 1, 8'h00, 1, "R8");
      // left shift through feedback wiring (R10)
      drive(1, 0, 4'h1, 0, 0, 0, 0, 0, 8'h00, 0, "R2");
      for (int i = 0; i < 4; i++)
         drive(1, 0, 4'h0, 0, 1, lpat[i], 0, lpat[3-i], 8'h00, 0, "R10");
      // asynchronous clear in mid-run (R4, R7)
      @(negedge clk);
      do_reset(4'hC);
      drive(0, 1, 4'h0, 0, 0, 0, 0, 1, 8'h00, 0, "R3");
      drive(0, 0, 4'h0, 0, 0, 0, 0, 1, 8'h00, 0, "R3");
      @(negedge clk);
      #8;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 5000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule